// File: doc/BRIEF.md
# Pipelined SRAM Write Command Sequencer

This block sits in the host interface of a search coprocessor. The host issues a write aimed at the associated SRAM as a multi-cycle command. The command occupies two consecutive command cycles (phase A, then phase B) on a 9-bit command bus and a wide data bus. Two further cycles follow in which the host keeps driving the data bus, but its contents carry no meaning. The block decodes the opcode, the address space and the device ID, rejects burst requests, and assembles the 22-bit SRAM address. The upper bits of that address come from the command bus and the lower bits come from the data bus.

An accepted write is not issued at once. It travels down a shift pipeline and reaches the external SRAM bus after a configurable latency, counted from phase B, which matches the search pipeline delay. Each pipeline stage holds its own address and valid bit, so writes issued as often as the protocol allows never collide. Several cascaded devices (up to eight) can share one command bus, because each device accepts only commands that carry its own ID.

Top module: `sramWrSeq`

## Requirements
- R1: After reset, chip enable, write enable, address strobe and output enable are all high, and the burst error flag is 0.
- R2: A command is formed only when cmdValid is 1 and cmdBus[1:0] equals the write opcode 2'b01 in two consecutive cycles (phase A, then phase B). If phase B lacks this, the command is dropped and produces no SRAM strobe.
- R3: The command is dropped unless dataBus[20:19] equals 2'b10 in phase A.
- R4: The command is dropped unless dataBus[25:21] equals the devId input in phase A.
- R5: The SRAM address of an accepted write is {cmdBus[8:6], dataBus[18:0]}, both taken in phase A.
- R6: If cmdBus[2] is 1 in phase A or phase B, the command is dropped. The burst error flag is then set and stays set until reset, but only when the ID and address space of that command matched this device.
- R7: The two cycles after phase B are ignored whatever the inputs carry. The next command may begin in the third cycle after phase B.
- R8: For latency L (0 to 7), chipEnN, writeEnN and addrStrobeN go low together for exactly one cycle, starting L clock edges after the edge that samples phase B. outEnN stays high at all times.
- R9: Writes issued every four cycles at the largest latency each produce their own one-cycle strobe carrying their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command bus qualifier |
| cmdBus | input | 9 | Opcode [1:0], burst request [2], upper SRAM address [8:6] |
| dataBus | input | 68 | Lower address [18:0], space select [20:19], target ID [25:21] |
| devId | input | 5 | ID of this device |
| latency | input | 3 | Pipeline delay to the SRAM bus, in cycles |
| sramAddr | output | 22 | SRAM address |
| chipEnN | output | 1 | SRAM chip enable, active low |
| writeEnN | output | 1 | SRAM write enable, active low |
| outEnN | output | 1 | SRAM output enable, active low |
| addrStrobeN | output | 1 | SRAM address latch strobe, active low |
| burstErr | output | 1 | Sticky flag for a rejected burst write |

## Verification
The write path is exercised with single writes at latencies 0, 3 and 5 and distinct addresses, which checks the delay count and the placement of the address fields. A train of writes issued every four cycles at latency 7 checks that stages in flight keep their own addresses. Commands with the wrong space code, the wrong ID, a missing phase B, or a burst bit in either phase confirm that each filter drops the write by itself, and a burst aimed at another device confirms that it leaves the error flag clear. Valid-looking write opcodes placed inside the ignored window, followed at once by a real command, tell a correct cycle count apart from one that reopens early or late.

// File: rtl/sramWrPkg.sv
package sramWrPkg;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] SPACE_SRAM = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_HALF_B, ST_IGN1, ST_IGN2} seqState_t;

  typedef struct packed {
    logic captureA;
    logic launch;
  } ctrlStrobe_t;
endpackage

// File: rtl/sramWrCtrl.sv
module sramWrCtrl
  import sramWrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        burstBit,
  input  logic        idHit,
  input  logic        spaceHit,
  output ctrlStrobe_t strobe,
  output logic        burstErr
);
  seqState_t state, nextState;
  logic isWrite, selA, burstA, errSet;

  assign isWrite = cmdValid && (cmdOp == OP_WRITE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: if (isWrite) begin
        strobe.captureA = 1'b1;
        nextState       = ST_HALF_B;
      end
      ST_HALF_B: if (isWrite) begin
        strobe.launch = selA && !burstA && !burstBit;
        errSet        = selA && (burstA || burstBit);
        nextState     = ST_IGN1;
      end else begin
        nextState = ST_IDLE;
      end
      ST_IGN1: nextState = ST_IGN2;
      ST_IGN2: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      selA     <= 1'b0;
      burstA   <= 1'b0;
      burstErr <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.captureA) begin
        selA   <= idHit && spaceHit;
        burstA <= burstBit;
      end
      if (errSet) burstErr <= 1'b1;
    end
  end

  // R2: a launch happens only while the write opcode is held in phase B
  p_launch_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> (cmdValid && cmdOp == OP_WRITE));
  // R6: no launch while a burst is requested
  p_no_burst_launch_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> !burstBit);
  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    burstErr |=> burstErr);
  // R7: the two cycles after phase B never start a command
  p_ignore_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> (!strobe.captureA && !strobe.launch) ##1 (!strobe.captureA && !strobe.launch));
endmodule

// File: rtl/sramWrPath.sv
module sramWrPath
  import sramWrPkg::*;
#(
  parameter int ID_W  = 5,
  parameter int LOW_W = 19,
  parameter int HI_W  = 3,
  parameter int LAT_W = 3,
  localparam int AW    = HI_W + LOW_W,
  localparam int DEPTH = 1 << LAT_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LOW_W-1:0] lowAddr,
  input  logic [1:0]       spaceSel,
  input  logic [ID_W-1:0]  idField,
  input  logic [ID_W-1:0]  devId,
  input  logic [HI_W-1:0]  hiAddr,
  input  logic [LAT_W-1:0] latency,
  output logic             idHit,
  output logic             spaceHit,
  output logic [AW-1:0]    sramAddr,
  output logic             chipEnN,
  output logic             writeEnN,
  output logic             outEnN,
  output logic             addrStrobeN
);
  logic [AW-1:0]    holdAddr;
  logic [DEPTH-1:0] pipeValid;
  logic [AW-1:0]    pipeAddr [DEPTH];
  logic             tapHit;

  assign idHit    = (idField == devId);
  assign spaceHit = (spaceSel == SPACE_SRAM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr     <= '0;
      pipeValid[0] <= 1'b0;
      pipeAddr[0]  <= '0;
    end else begin
      if (strobe.captureA) holdAddr <= {hiAddr, lowAddr};
      pipeValid[0] <= strobe.launch;
      pipeAddr[0]  <= holdAddr;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipeValid[i] <= 1'b0;
        pipeAddr[i]  <= '0;
      end else begin
        pipeValid[i] <= pipeValid[i-1];
        pipeAddr[i]  <= pipeAddr[i-1];
      end
    end
  end

  assign tapHit      = pipeValid[latency];
  assign sramAddr    = pipeAddr[latency];
  assign chipEnN     = ~tapHit;
  assign writeEnN    = ~tapHit;
  assign addrStrobeN = ~tapHit;
  assign outEnN      = 1'b1;

  // R8: each write strobe lasts exactly one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEnN |=> chipEnN);
  // R5: address is defined whenever the strobe is active
  p_addr_known_r5: assert property (@(posedge clk) disable iff (!rstN)
    !chipEnN |-> !$isunknown(sramAddr));
  // R8: enables move together and output enable stays high during a write
  p_strobes_aligned_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEnN |-> (!writeEnN && !addrStrobeN && outEnN));
endmodule

// File: rtl/sramWrSeq.sv
module sramWrSeq
  import sramWrPkg::*;
#(
  parameter int DATA_W = 68,
  parameter int ID_W   = 5,
  parameter int LOW_W  = 19,
  parameter int HI_W   = 3,
  parameter int LAT_W  = 3,
  localparam int AW      = HI_W + LOW_W,
  localparam int SPACE_LO = LOW_W,
  localparam int ID_LO    = LOW_W + 2,
  localparam int USED_W   = ID_LO + ID_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [8:0]        cmdBus,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [ID_W-1:0]   devId,
  input  logic [LAT_W-1:0]  latency,
  output logic [AW-1:0]     sramAddr,
  output logic              chipEnN,
  output logic              writeEnN,
  output logic              outEnN,
  output logic              addrStrobeN,
  output logic              burstErr
);
  ctrlStrobe_t strobe;
  logic idHit, spaceHit;
  logic unusedBits;

  assign unusedBits = ^{dataBus[DATA_W-1:USED_W], cmdBus[5:3]};

  sramWrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdBus[1:0]),
    .burstBit(cmdBus[2]), .idHit(idHit), .spaceHit(spaceHit),
    .strobe(strobe), .burstErr(burstErr)
  );

  sramWrPath #(.ID_W(ID_W), .LOW_W(LOW_W), .HI_W(HI_W), .LAT_W(LAT_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lowAddr(dataBus[LOW_W-1:0]), .spaceSel(dataBus[SPACE_LO+1:SPACE_LO]),
    .idField(dataBus[ID_LO+ID_W-1:ID_LO]), .devId(devId), .hiAddr(cmdBus[8:6]),
    .latency(latency), .idHit(idHit), .spaceHit(spaceHit),
    .sramAddr(sramAddr), .chipEnN(chipEnN), .writeEnN(writeEnN),
    .outEnN(outEnN), .addrStrobeN(addrStrobeN)
  );
endmodule

// File: tb/sim_sramWrSeq.sv
module sim_sramWrSeq;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MY_ID = 5'd13;

  logic        clk = 0, rstN = 0, cmdValid = 0;
  logic [8:0]  cmdBus = '0;
  logic [67:0] dataBus = '0;
  logic [2:0]  latency = '0;
  logic [21:0] sramAddr;
  logic chipEnN, writeEnN, outEnN, addrStrobeN, burstErr;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, expErr = 0;
  string curReq = "R1";
  bit expPulse [int];
  logic [21:0] expAddr [int];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sramWrSeq u0 (.clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBus(cmdBus),
    .dataBus(dataBus), .devId(MY_ID), .latency(latency), .sramAddr(sramAddr),
    .chipEnN(chipEnN), .writeEnN(writeEnN), .outEnN(outEnN),
    .addrStrobeN(addrStrobeN), .burstErr(burstErr));

  // per-cycle comparison against the reference schedule (R8, R5)
  always @(negedge clk) if (rstN && !done) begin
    bit want;
    want = expPulse.exists(cyc);
    checks++;
    if (chipEnN !== !want || writeEnN !== !want || addrStrobeN !== !want || outEnN !== 1'b1 ||
        (want && sramAddr !== expAddr[cyc])) begin
      failures++;
      $display("FAIL %s cyc=%0d ce=%b we=%b ale=%b oe=%b addr=%h expected pulse=%b addr=%h",
               curReq, cyc, chipEnN, writeEnN, addrStrobeN, outEnN, sramAddr,
               want, want ? expAddr[cyc] : 22'h0);
    end
  end

  task automatic checkErr(input string tag);
    checks++;
    if (burstErr !== expErr) begin
      failures++;
      $display("FAIL %s burstErr actual=%b expected=%b", tag, burstErr, expErr);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdValid = 0; cmdBus = '0; dataBus = '0;
    end
  endtask

  function automatic logic [67:0] mkData(input logic [4:0] id, input logic [1:0] sp,
                                         input logic [18:0] lo);
    logic [67:0] d;
    d = {42'h2A5A5A5A5A5, id, sp, lo};
    return d;
  endfunction

  task automatic issue(input logic [4:0] id, input logic [1:0] sp, input logic [18:0] lo,
                       input logic [2:0] hi, input bit bA, input bit bB, input bit holdB,
                       input bit junk);
    bit sel, acc;
    int edgeB;
    sel = (id == MY_ID) && (sp == 2'b10);
    acc = holdB && sel && !bA && !bB;
    @(negedge clk);
    cmdValid = 1; cmdBus = {hi, 3'b000, bA, 2'b01}; dataBus = mkData(id, sp, lo);
    @(negedge clk);
    cmdValid = holdB; cmdBus = {3'b111, 3'b000, bB, 2'b01};
    edgeB = cyc + 1;
    if (acc) begin
      expPulse[edgeB + int'(latency)] = 1;
      expAddr[edgeB + int'(latency)]  = {hi, lo};
    end
    if (holdB && sel && (bA || bB)) expErr = 1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (junk && holdB) begin
        cmdValid = 1; cmdBus = {3'b101, 3'b000, 1'b0, 2'b01};
        dataBus = mkData(MY_ID, 2'b10, 19'h7FFFF);
      end else begin
        cmdValid = 0; cmdBus = '0; dataBus = '0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    checks++;
    if (chipEnN !== 1 || writeEnN !== 1 || addrStrobeN !== 1 || outEnN !== 1 || burstErr !== 0) begin
      failures++;
      $display("FAIL R1 strobes ce=%b we=%b ale=%b oe=%b err=%b expected 1111 err 0",
               chipEnN, writeEnN, addrStrobeN, outEnN, burstErr);
    end

    curReq = "R8"; latency = 3'd0;
    issue(MY_ID, 2'b10, 19'h12345, 3'd5, 0, 0, 1, 0); idle(10);
    curReq = "R5"; latency = 3'd3;
    issue(MY_ID, 2'b10, 19'h00001, 3'd7, 0, 0, 1, 0); idle(2);
    issue(MY_ID, 2'b10, 19'h7FFFF, 3'd0, 0, 0, 1, 0); idle(10);
    curReq = "R8"; latency = 3'd5;
    issue(MY_ID, 2'b10, 19'h2AAAA, 3'd2, 0, 0, 1, 0); idle(12);

    curReq = "R9"; latency = 3'd7;
    issue(MY_ID, 2'b10, 19'h11111, 3'd1, 0, 0, 1, 0);
    issue(MY_ID, 2'b10, 19'h22222, 3'd2, 0, 0, 1, 0);
    issue(MY_ID, 2'b10, 19'h33333, 3'd3, 0, 0, 1, 0);
    issue(MY_ID, 2'b10, 19'h44444, 3'd4, 0, 0, 1, 0);
    idle(14);

    curReq = "R3"; latency = 3'd2;
    issue(MY_ID, 2'b01, 19'h0ABCD, 3'd1, 0, 0, 1, 0);
    issue(MY_ID, 2'b11, 19'h0ABCD, 3'd1, 0, 0, 1, 0);
    issue(MY_ID, 2'b00, 19'h0ABCD, 3'd1, 0, 0, 1, 0); idle(8);
    curReq = "R4";
    issue(5'd12, 2'b10, 19'h0BEEF, 3'd6, 0, 0, 1, 0);
    issue(5'd29, 2'b10, 19'h0BEEF, 3'd6, 0, 0, 1, 0); idle(8);

    curReq = "R2";
    issue(MY_ID, 2'b10, 19'h05555, 3'd3, 0, 0, 0, 0);
    issue(MY_ID, 2'b10, 19'h06666, 3'd4, 0, 0, 1, 0); idle(8);

    curReq = "R7";
    issue(MY_ID, 2'b10, 19'h01234, 3'd1, 0, 0, 1, 1);
    issue(MY_ID, 2'b10, 19'h04321, 3'd6, 0, 0, 1, 1); idle(10);

    curReq = "R6";
    issue(5'd3, 2'b10, 19'h0F00F, 3'd2, 1, 0, 1, 0); idle(4);
    checkErr("R6 burst to other device");
    issue(MY_ID, 2'b10, 19'h0F00F, 3'd2, 0, 1, 1, 0); idle(8);
    checkErr("R6 burst in phase B");
    issue(MY_ID, 2'b10, 19'h0E00E, 3'd3, 1, 0, 1, 0); idle(8);
    checkErr("R6 burst in phase A");
    issue(MY_ID, 2'b10, 19'h0D00D, 3'd4, 0, 0, 1, 0); idle(8);
    checkErr("R6 flag stays set");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule